// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bus Master

This block is the host end of a shared, active-low, single-wire control bus on which every symbol is a low pulse whose length carries its meaning: a short pulse is a zero, a medium pulse is a one, and a long pulse is a transaction marker. On one request, the block sends a complete command. Each frame opens with a transaction pulse and a three-bit opcode header, carries an address, a data word or a run of read prompts, and closes with a transaction pulse followed by three ones. The line is driven only through an open-drain pull-down output. The wired line is read back through a two-flop synchronizer.

The user places an opcode, a 4-bit target address and a word on the request port for one cycle. The block raises `busy`, sends the pulse train, and pulses `done` when the last frame has closed. Writes and reads are sent after an address frame that selects the target. Broadcasts and one form of software reset go to every target with no address frame. In a read, the block sends one short prompt per data bit and then lets the line go. It samples the reply once, in the middle of the valid window, and builds the returned word least significant bit first. Every pulse length is derived from the `CLK_MHZ` parameter (clock cycles per microsecond).

Top module: `pwb_master`

## Requirements
- R1: The host holds the line low for exactly 5·CLK_MHZ cycles for a zero, 30·CLK_MHZ for a one and 100·CLK_MHZ for a transaction pulse. It leaves the line released for at least CLK_MHZ cycles between consecutive pulses.
- R2: Every frame starts with a transaction pulse and then three header bits, sent in the order listed: address 0,1,0; write 0,0,1; read 1,0,1; broadcast 0,0,0. Every frame ends with a transaction pulse and then 1,1,1.
- R3: The 4-bit address is sent after the address header, and the WORD_W-bit write or broadcast word is sent after its header. Both are sent least significant bit first.
- R4: The op codes are address-only = 0, write = 1, read = 2, broadcast = 3. Op 0 sends one address frame. Op 1 sends an address frame and then a write frame. Op 2 sends an address frame and then a read frame. Op 3 sends a single broadcast frame with no address frame.
- R5: A read frame carries WORD_W prompts between its header and its close. Each prompt pulls the line low for max(CLK_MHZ/2,1) cycles. The next pulse starts no sooner than 13·CLK_MHZ cycles after the prompt started.
- R6: Each prompt produces one read bit, taken from the synchronized line about 3.5 µs after the prompt began. A low line gives 0 and a high line gives 1. The first prompt fills bit 0 of `rd_data`. `rd_valid` pulses together with `done` only at the end of a read.
- R7: Op 4 is a software reset sent as a broadcast frame of WORD_W ones. Op 5 is a software reset sent as an address frame followed by a write frame of WORD_W ones. In both, `wdata` is ignored.
- R8: An accepted request sets `busy` from the next cycle. `done` is high for one cycle at the end of the sequence, on the same edge at which `busy` falls. A request made while busy is ignored. Op codes 6 and 7 are ignored and leave the block idle with the line released.
- R9: After reset, `bus_pull`, `busy`, `done`, `rd_valid` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_MHZ cycles per microsecond |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe, accepted only while idle |
| op | input | 3 | Command code (0..5) |
| addr | input | 4 | Target address |
| wdata | input | WORD_W | Word for write or broadcast |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence strobe |
| rd_data | output | WORD_W | Last word read, bit 0 first received |
| rd_valid | output | 1 | `rd_data` is fresh; high with `done` after a read |
| bus_pull | output | 1 | 1 pulls the shared line low (open-drain enable) |
| bus_in | input | 1 | Level of the shared line |

## Verification
The timing of each result is as follows:
- `busy` is due one cycle after the request edge.
- A pulse starts one cycle after the sequencer launches it.
- Each read bit is due SAMP = 3.5·CLK_MHZ+2 cycles after its prompt rises, which accounts for the two synchronizer flops.
- `done` and `rd_valid` are due two cycles after the final ones-slot expires.

The bench drives all inputs on falling edges and checks at falling edges. Its line monitor and target model run on rising edges and see only register outputs that were settled before the edge. Pulse lengths and gaps are therefore counted in whole cycles.

The modelled target starts its reply two cycles after it sees a prompt begin and holds the line low through cycle 14. This covers the sample point with margin on both sides, so the read results do not depend on cycle-level alignment.

// File: rtl/pwb_pkg.sv
// Shared types for the single-wire pulse-width bus master.
// Assumes: op codes are fixed by the user-side contract (0..5 valid).
package pwb_pkg;

    typedef enum logic [1:0] {
        SYM_ZERO   = 2'd0,
        SYM_ONE    = 2'd1,
        SYM_TRANS  = 2'd2,
        SYM_PROMPT = 2'd3
    } sym_t;

    typedef enum logic [1:0] {
        FK_ADDR  = 2'd0,
        FK_WRITE = 2'd1,
        FK_READ  = 2'd2,
        FK_BCAST = 2'd3
    } frame_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_OPEN  = 3'd1,
        ST_HDR   = 3'd2,
        ST_BODY  = 3'd3,
        ST_CLOSE = 3'd4,
        ST_TAIL  = 3'd5
    } seq_state_t;

    localparam logic [2:0] OP_ADDR      = 3'd0;
    localparam logic [2:0] OP_WRITE     = 3'd1;
    localparam logic [2:0] OP_READ      = 3'd2;
    localparam logic [2:0] OP_BCAST     = 3'd3;
    localparam logic [2:0] OP_RST_BCAST = 3'd4;
    localparam logic [2:0] OP_RST_ADDR  = 3'd5;

    // Header bits; bit 2 goes out first.
    function automatic logic [2:0] hdr_code(input frame_t f);
        case (f)
            FK_ADDR:  hdr_code = 3'b010;
            FK_WRITE: hdr_code = 3'b001;
            FK_READ:  hdr_code = 3'b101;
            default:  hdr_code = 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/pwb_sync.sv
// Two-flop synchronizer for the shared line level.
// Assumes: the idle line is high, so both stages reset to 1.
module pwb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic stage1;

    // Resample the external level twice before use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= 1'b1;
            sync_out <= 1'b1;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/pwb_pulse_gen.sv
// Emits one bus symbol per launch: a low pulse of the symbol's length
// followed by released time. It reports the end of the slot and, for
// prompts, a strobe at the read sample point.
// Assumes: go arrives only while idle; CLK_MHZ >= 1.
module pwb_pulse_gen
    import pwb_pkg::*;
#(
    parameter int CLK_MHZ = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  sym_t sym,
    output logic pull,
    output logic slot_done,
    output logic samp_stb
);
    localparam int W0    = 5 * CLK_MHZ;
    localparam int W1    = 30 * CLK_MHZ;
    localparam int WT    = 100 * CLK_MHZ;
    localparam int WP    = (CLK_MHZ / 2 > 0) ? CLK_MHZ / 2 : 1;
    localparam int GAP   = CLK_MHZ;
    localparam int RSLOT = 13 * CLK_MHZ;
    localparam int SAMP  = (7 * CLK_MHZ) / 2 + 2;
    localparam int CW    = $clog2(WT + 2 * GAP + 4);

    localparam logic [CW-1:0] W0_C    = CW'(W0);
    localparam logic [CW-1:0] W1_C    = CW'(W1);
    localparam logic [CW-1:0] WT_C    = CW'(WT);
    localparam logic [CW-1:0] WP_C    = CW'(WP);
    localparam logic [CW-1:0] GAP_C   = CW'(GAP);
    localparam logic [CW-1:0] RSLOT_C = CW'(RSLOT);
    localparam logic [CW-1:0] SAMP_C  = CW'(SAMP);
    localparam logic [CW-1:0] CMAX_C  = {CW{1'b1}};

    logic          active;
    logic          is_prm;
    logic [CW-1:0] cnt;
    logic [CW-1:0] low_len;
    logic [CW-1:0] slot_len;
    logic [CW-1:0] lw;
    logic [CW-1:0] sl;

    // Low time and slot length for the symbol about to launch.
    always_comb begin
        case (sym)
            SYM_ZERO:   lw = W0_C;
            SYM_ONE:    lw = W1_C;
            SYM_TRANS:  lw = WT_C;
            default:    lw = WP_C;
        endcase
        sl = (sym == SYM_PROMPT) ? RSLOT_C : lw + GAP_C;
    end

    // Slot timer: pull low for low_len cycles, then release until slot_len.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            is_prm    <= 1'b0;
            cnt       <= '0;
            low_len   <= '0;
            slot_len  <= '0;
            pull      <= 1'b0;
            slot_done <= 1'b0;
        end else begin
            slot_done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active   <= 1'b1;
                    cnt      <= CW'(1);
                    pull     <= 1'b1;
                    low_len  <= lw;
                    slot_len <= sl;
                    is_prm   <= (sym == SYM_PROMPT);
                end
            end else begin
                cnt  <= cnt + CW'(1);
                pull <= (cnt < low_len);
                if (cnt == slot_len) begin
                    active    <= 1'b0;
                    slot_done <= 1'b1;
                    pull      <= 1'b0;
                end
            end
        end
    end

    // Read sample point within a prompt slot.
    assign samp_stb = active && is_prm && (cnt == SAMP_C);

    // Run-length counters for the checks below.
    logic [CW-1:0] hi_run;
    logic [CW-1:0] lo_run;

    // Track how long the line has been pulled and released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= CMAX_C;
        end else begin
            hi_run <= pull ? hi_run + CW'(1) : '0;
            lo_run <= pull ? '0 : ((lo_run == CMAX_C) ? lo_run : lo_run + CW'(1));
        end
    end

    // R1
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull) |-> (hi_run == low_len));

    // R1
    pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull) |-> (lo_run >= GAP_C));

    // R5
    prompt_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_stb |-> !pull);
endmodule

// File: rtl/pwb_sequencer.sv
// Command sequencer: turns one accepted request into one or two frames
// (open, header, body, close, tail), launches one symbol at a time into
// the pulse generator and gathers read bits, first bit into bit 0.
// Assumes: slot_done follows every go; samp_stb occurs only in prompts.
module pwb_sequencer
    import pwb_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [2:0]        op,
    input  logic [3:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              slot_done,
    input  logic              samp_stb,
    input  logic              line_bit,
    output logic              go,
    output sym_t              sym,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int BODY_MAX = (WORD_W > 4) ? WORD_W : 4;
    localparam int IW       = $clog2(BODY_MAX) + 1;

    localparam logic [IW-1:0] LAST_HDR  = IW'(2);
    localparam logic [IW-1:0] LAST_ADDR = IW'(3);
    localparam logic [IW-1:0] LAST_WORD = IW'(WORD_W - 1);

    seq_state_t        state;
    frame_t            cur;
    frame_t            nxt_frame;
    logic              has_next;
    logic [IW-1:0]     idx;
    logic              launched;
    logic [3:0]        addr_q;
    logic [WORD_W-1:0] data_q;
    logic              ones_q;
    logic              accept;
    logic [IW-1:0]     last_body;
    logic [2:0]        hdr;
    logic              hdr_bit;

    assign accept    = (state == ST_IDLE) && req && (op <= OP_RST_ADDR);
    assign last_body = (cur == FK_ADDR) ? LAST_ADDR : LAST_WORD;
    assign hdr       = hdr_code(cur);
    assign go        = (state != ST_IDLE) && !launched;

    // Pick the header bit for the current position, first character first.
    always_comb begin
        case (idx[1:0])
            2'd0:    hdr_bit = hdr[2];
            2'd1:    hdr_bit = hdr[1];
            default: hdr_bit = hdr[0];
        endcase
    end

    // Symbol to launch in the current state.
    always_comb begin
        case (state)
            ST_OPEN, ST_CLOSE: sym = SYM_TRANS;
            ST_HDR:            sym = hdr_bit ? SYM_ONE : SYM_ZERO;
            ST_TAIL:           sym = SYM_ONE;
            ST_BODY: begin
                if (cur == FK_READ)
                    sym = SYM_PROMPT;
                else if (cur == FK_ADDR)
                    sym = addr_q[0] ? SYM_ONE : SYM_ZERO;
                else
                    sym = (ones_q || data_q[0]) ? SYM_ONE : SYM_ZERO;
            end
            default:           sym = SYM_ZERO;
        endcase
    end

    // Accept requests, step through frames, finish with done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur       <= FK_ADDR;
            nxt_frame <= FK_ADDR;
            has_next  <= 1'b0;
            idx       <= '0;
            launched  <= 1'b0;
            addr_q    <= '0;
            data_q    <= '0;
            ones_q    <= 1'b0;
            busy      <= 1'b0;
            done      <= 1'b0;
            rd_valid  <= 1'b0;
        end else begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
            if (go)
                launched <= 1'b1;
            if (accept) begin
                busy   <= 1'b1;
                state  <= ST_OPEN;
                idx    <= '0;
                addr_q <= addr;
                data_q <= wdata;
                ones_q <= (op == OP_RST_BCAST) || (op == OP_RST_ADDR);
                case (op)
                    OP_ADDR: begin
                        cur <= FK_ADDR;  has_next <= 1'b0; nxt_frame <= FK_ADDR;
                    end
                    OP_WRITE, OP_RST_ADDR: begin
                        cur <= FK_ADDR;  has_next <= 1'b1; nxt_frame <= FK_WRITE;
                    end
                    OP_READ: begin
                        cur <= FK_ADDR;  has_next <= 1'b1; nxt_frame <= FK_READ;
                    end
                    default: begin
                        cur <= FK_BCAST; has_next <= 1'b0; nxt_frame <= FK_BCAST;
                    end
                endcase
            end else if ((state != ST_IDLE) && slot_done) begin
                launched <= 1'b0;
                case (state)
                    ST_OPEN: begin
                        state <= ST_HDR;
                        idx   <= '0;
                    end
                    ST_HDR: begin
                        if (idx == LAST_HDR) begin
                            state <= ST_BODY;
                            idx   <= '0;
                        end else begin
                            idx <= idx + IW'(1);
                        end
                    end
                    ST_BODY: begin
                        if (cur == FK_ADDR)
                            addr_q <= {1'b0, addr_q[3:1]};
                        else if (cur != FK_READ)
                            data_q <= data_q >> 1;
                        if (idx == last_body)
                            state <= ST_CLOSE;
                        else
                            idx <= idx + IW'(1);
                    end
                    ST_CLOSE: begin
                        state <= ST_TAIL;
                        idx   <= '0;
                    end
                    ST_TAIL: begin
                        if (idx != LAST_HDR) begin
                            idx <= idx + IW'(1);
                        end else if (has_next) begin
                            cur      <= nxt_frame;
                            has_next <= 1'b0;
                            state    <= ST_OPEN;
                            idx      <= '0;
                        end else begin
                            state    <= ST_IDLE;
                            busy     <= 1'b0;
                            done     <= 1'b1;
                            rd_valid <= (cur == FK_READ);
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Shift in one read bit per prompt, so the first bit ends in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (samp_stb)
            rd_data <= {line_bit, rd_data[WORD_W-1:1]};
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> done);

    // R4
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> busy);
endmodule

// File: rtl/pwb_master.sv
// Top of the single-wire pulse-width bus master. Connects the command
// sequencer, the symbol pulse generator and the line synchronizer.
// Assumes: bus_pull drives an open-drain pull-down on a line with an
// external pull-up; bus_in reads that line.
module pwb_master
    import pwb_pkg::*;
#(
    parameter int CLK_MHZ = 100,
    parameter int WORD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [2:0]        op,
    input  logic [3:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              bus_pull,
    input  logic              bus_in
);
    logic go;
    sym_t sym;
    logic slot_done;
    logic samp_stb;
    logic line_bit;

    pwb_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_in),
        .sync_out (line_bit)
    );

    pwb_pulse_gen #(.CLK_MHZ(CLK_MHZ)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .sym       (sym),
        .pull      (bus_pull),
        .slot_done (slot_done),
        .samp_stb  (samp_stb)
    );

    pwb_sequencer #(.WORD_W(WORD_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .op        (op),
        .addr      (addr),
        .wdata     (wdata),
        .slot_done (slot_done),
        .samp_stb  (samp_stb),
        .line_bit  (line_bit),
        .go        (go),
        .sym       (sym),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );
endmodule

// File: tb/test_pwb_master.sv
// Bench: small configuration (2 cycles per microsecond, 8-bit word).
// A line monitor decodes the pulse lengths, and a target model answers prompts.
module test_pwb_master;
    localparam int MHZ = 2;
    localparam int NW  = 8;
    localparam int W0  = 5 * MHZ, W1 = 30 * MHZ, WT = 100 * MHZ, WP = 1;
    localparam int GAP = MHZ, RSLOT = 13 * MHZ;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [2:0]    op_i = '0;
    logic [3:0]    addr_i = '0;
    logic [NW-1:0] wdata_i = '0;
    logic          busy, done, rd_valid, bus_pull;
    logic [NW-1:0] rd_data;
    logic          dev_pull = 1'b0;
    logic          bus_in;

    assign bus_in = !(bus_pull || dev_pull);

    pwb_master #(.CLK_MHZ(MHZ), .WORD_W(NW)) i_pwb_master (
        .clk(clk), .rst_n(rst_n), .req(req), .op(op_i), .addr(addr_i),
        .wdata(wdata_i), .busy(busy), .done(done), .rd_data(rd_data),
        .rd_valid(rd_valid), .bus_pull(bus_pull), .bus_in(bus_in)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0;
    int log_sym [0:255];
    int log_t   [0:255];
    int exp_sym [0:255];
    int nlog = 0, nexp = 0, min_gap = 9999;
    int hi_run = 0, lo_run = 0, cyc = 0;
    logic lprev = 1'b0;
    logic [NW-1:0] rbits = '0;
    int ridx = 0, dcyc = 99;
    logic dprev = 1'b0;
    logic got_rv;
    logic [NW-1:0] got_rd;

    function automatic int classify(input int w);
        if (w == W0) return 0;
        if (w == W1) return 1;
        if (w == WT) return 2;
        if (w == WP) return 3;
        return 9;
    endfunction

    // Line monitor: log each host pulse by its length, and its start cycle.
    always @(posedge clk) begin
        cyc++;
        if (bus_pull) begin
            if (!lprev) begin
                if (nlog < 256) log_t[nlog] = cyc;
                if (nlog > 0 && lo_run < min_gap) min_gap = lo_run;
            end
            hi_run++;
            lo_run = 0;
        end else begin
            if (lprev) begin
                if (nlog < 256) log_sym[nlog] = classify(hi_run);
                nlog++;
            end
            hi_run = 0;
            lo_run++;
        end
        lprev = bus_pull;
    end

    // Target model: a prompt (line already released 2 cycles after it starts)
    // gets a reply; a 0 bit holds the line low until cycle 14.
    always @(posedge clk) begin
        if (bus_pull && !dprev) dcyc = 0;
        else if (dcyc < 99) dcyc++;
        if (dcyc == 2 && !bus_pull) begin
            dev_pull <= !rbits[ridx % NW];
            ridx++;
        end
        if (dcyc == 14) dev_pull <= 1'b0;
        dprev = bus_pull;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    task automatic clear_logs();
        nlog = 0; nexp = 0; min_gap = 9999;
    endtask

    task automatic e_sym(input int s);
        exp_sym[nexp] = s; nexp++;
    endtask

    task automatic e_bits(input longint v, input int n);
        for (int i = 0; i < n; i++) e_sym(int'((v >> i) & 1));
    endtask

    task automatic e_frame(input int b0, input int b1, input int b2);
        e_sym(2); e_sym(b0); e_sym(b1); e_sym(b2);
    endtask

    task automatic e_close();
        e_sym(2); e_sym(1); e_sym(1); e_sym(1);
    endtask

    task automatic e_addr(input int a);
        e_frame(0, 1, 0); e_bits(a, 4); e_close();
    endtask

    task automatic chk_seq(input string rq);
        int diff = -1;
        for (int i = 0; i < nexp; i++)
            if (diff < 0 && (i >= nlog || log_sym[i] != exp_sym[i])) diff = i;
        if (diff < 0 && nlog != nexp) diff = nexp;
        if (diff < 0)
            chk(1'b1, rq, "sequence", 0, 0);
        else
            chk(1'b0, rq, $sformatf("symbol %0d (count %0d/%0d)", diff, nlog, nexp),
                (diff < nlog) ? log_sym[diff] : -1,
                (diff < nexp) ? exp_sym[diff] : -1);
    endtask

    task automatic run(input int op, input int a, input longint w);
        @(negedge clk);
        op_i = 3'(op); addr_i = 4'(a); wdata_i = NW'(w); req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        while (!done) @(negedge clk);
        got_rv = rd_valid; got_rd = rd_data;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(!bus_pull && !busy && !done && !rd_valid && rd_data == 0, "R9",
            "reset outputs", {bus_pull, busy, done, rd_valid, rd_data}, 0);

        // R2 R3 R1: every address, address-only op
        for (int a = 0; a < 16; a++) begin
            clear_logs(); e_addr(a);
            run(0, a, 0);
            chk_seq("R3 address frame");
            chk(min_gap >= GAP, "R1", "gap", min_gap, GAP);
            chk(!got_rv, "R6", "rd_valid on non-read", got_rv, 0);
        end

        // R4 R3 write: address frame then write frame
        begin
            logic [NW-1:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
            for (int k = 0; k < 4; k++) begin
                clear_logs(); e_addr(k * 5);
                e_frame(0, 0, 1); e_bits(pats[k], NW); e_close();
                run(1, k * 5, pats[k]);
                chk_seq("R4 write");
            end
        end

        // R4 broadcast: no address frame
        clear_logs(); e_frame(0, 0, 0); e_bits(8'h96, NW); e_close();
        run(3, 7, 8'h96);
        chk_seq("R4 broadcast");

        // R7 software reset both forms, wdata ignored
        clear_logs(); e_frame(0, 0, 0); e_bits(8'hFF, NW); e_close();
        run(4, 3, 8'h00);
        chk_seq("R7 reset by broadcast");
        clear_logs(); e_addr(9); e_frame(0, 0, 1); e_bits(8'hFF, NW); e_close();
        run(5, 9, 8'h12);
        chk_seq("R7 reset by address+write");

        // R5 R6 reads
        begin
            logic [NW-1:0] rp [5] = '{8'h00, 8'hFF, 8'h5A, 8'h81, 8'h3C};
            for (int k = 0; k < 5; k++) begin
                int min_sp = 9999;
                rbits = rp[k]; ridx = 0;
                clear_logs(); e_addr(k + 10);
                e_frame(1, 0, 1);
                for (int i = 0; i < NW; i++) e_sym(3);
                e_close();
                run(2, k + 10, 0);
                chk_seq("R5 read frame");
                for (int i = 0; i + 1 < nlog; i++)
                    if (log_sym[i] == 3 && log_t[i + 1] - log_t[i] < min_sp)
                        min_sp = log_t[i + 1] - log_t[i];
                chk(min_sp >= RSLOT, "R5", "prompt spacing", min_sp, RSLOT);
                chk(got_rv && got_rd == rp[k], "R6", "read word",
                    {got_rv, got_rd}, {1'b1, rp[k]});
            end
        end

        // R8 handshake and ignored requests
        clear_logs(); e_addr(6);
        @(negedge clk);
        op_i = 3'd0; addr_i = 4'd6; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(busy, "R8", "busy after accept", busy, 1);
        repeat (3) @(negedge clk);
        op_i = 3'd3; wdata_i = 8'h55; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        while (!done) @(negedge clk);
        chk(!busy, "R8", "busy low with done", busy, 0);
        @(negedge clk);
        chk(!done, "R8", "done one cycle", done, 0);
        repeat (4) @(negedge clk);
        chk_seq("R8 request while busy ignored");
        chk(!busy, "R8", "idle after ignored request", busy, 0);

        for (int o = 6; o < 8; o++) begin
            clear_logs();
            @(negedge clk);
            op_i = 3'(o); req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            repeat (20) @(negedge clk);
            chk(!busy && !bus_pull && nlog == 0, "R8", "undefined op ignored",
                {busy, bus_pull, 8'(nlog)}, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule